// File: doc/BRIEF.md
# Dual-Bus Virtual Serial Port

This block is a serial port with no line. It has two register front-ends shaped like a UART. One sits on a host bus and the other on a management bus, and each runs on its own clock. A byte written to the data register on one side shows up in the data register on the other side. Each direction carries its bytes through its own 16-entry asynchronous FIFO. The FIFO pointers are Gray-coded and reach the other clock domain through two-flop synchronizers. Neither side does baud-rate generation or serial shifting. Bytes move at bus speed.

Each side sees line status (data ready, overrun, transmitter empty) and drives its own interrupt. The management side also owns the host side's configuration. It sets the host enable, a 16-bit base address and a 4-bit interrupt number, and all three are brought out on ports for the host-bus decoder. The host side cannot change them. While the host side is disabled, the host interface is inert.

Top module: `vuart_bridge`

## Requirements
- R1: A byte written to register 0 (data) on one side is read from register 0 on the other side. Bytes arrive in write order and none is lost or added. This holds in both directions and for host-to-management clock ratios from 1:3 to 3:1.
- R2: Each direction buffers 16 bytes. A data write while that direction is full is dropped, and the 16 buffered bytes stay intact.
- R3: A dropped write sets the overrun bit (bit 1 of register 2) on the receiving side. Reading register 2 on that side clears the bit.
- R4: Bit 0 of register 2 is set exactly when the receive FIFO is non-empty. A read of register 0 pops one byte. A read of register 0 while the FIFO is empty returns 0x00 and pops nothing.
- R5: Bit 2 of register 2 is set when the side's own outbound FIFO is empty.
- R6: Register 1 (interrupt enable) uses bit 0 for receive-data and bit 1 for transmitter-empty. The side's irq output is the OR of the enabled conditions. Register 1 resets to 0.
- R7: Management-only registers hold the host configuration: register 4 bit 0 is the host enable, registers 5 and 6 are the base address low and high bytes, and register 7 bits 3:0 are the interrupt number. They drive the cfg ports and read back. Host writes to addresses 4 to 7 have no effect.
- R8: While the host enable is 0, host reads and writes are ignored: h_rdata holds, nothing is pushed or popped and register 1 keeps its value. h_irq is also held low.
- R9: After reset both rdata outputs, both irq outputs and all cfg ports are 0, and register 2 on each side reads 0x04.
- R10: Read data appears on rdata on the clock after the read strobe and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host bus clock |
| h_rst | input | 1 | Host domain synchronous reset, active high |
| h_addr | input | 3 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| h_irq | output | 1 | Host interrupt |
| m_clk | input | 1 | Management bus clock |
| m_rst | input | 1 | Management domain synchronous reset, active high |
| m_addr | input | 3 | Management register address |
| m_wr | input | 1 | Management write strobe |
| m_rd | input | 1 | Management read strobe |
| m_wdata | input | 8 | Management write data |
| m_rdata | output | 8 | Management read data, registered |
| m_irq | output | 1 | Management interrupt |
| cfg_host_en | output | 1 | Host side enable |
| cfg_host_base | output | 16 | Host side base address |
| cfg_host_irq_id | output | 4 | Host side interrupt number |

## Verification
A corrupted FIFO pointer or a broken synchronizer shows up at the far side's data register a few cycles of the slower clock later. It appears as a byte that is missing, repeated or out of order, or as a data-ready bit that disagrees with the number of bytes drained. A drop flag that never crosses leaves the overrun bit clear after a 17-byte burst. Wrong gating of the host enable shows as a host write that reaches the management side, or as a host interrupt that stays high while disabled. Both become visible within the synchronizer delay of the enable.

// File: rtl/vuart_pkg.sv
package vuart_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int BASE_W   = 16;
  localparam int IRQ_ID_W = 4;
  localparam int DEF_AW   = 4;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_IER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LSR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_BLO  = 3'd5;
  localparam logic [ADDR_W-1:0] A_BHI  = 3'd6;
  localparam logic [ADDR_W-1:0] A_IRQ  = 3'd7;

  localparam int LSR_DR  = 0;
  localparam int LSR_OE  = 1;
  localparam int LSR_TXE = 2;
  localparam int IER_RX  = 0;
  localparam int IER_TX  = 1;
endpackage

// File: rtl/vuart_sync.sv
module vuart_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/vuart_afifo.sv
module vuart_afifo #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  output logic          wempty,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rempty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_n, rbin_n;

  assign wbin_n = wbin + PW'(1);
  assign rbin_n = rbin + PW'(1);

  // write domain
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wen && !wfull) begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wen && !wfull) mem[wbin[AW-1:0]] <= wdata;
  end

  vuart_sync #(.W(PW)) u_rsync (
    .clk (wclk),
    .rst (wrst),
    .d   (rgray),
    .q   (rgray_w)
  );

  assign wfull  = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign wempty = (wgray == rgray_w);

  // read domain
  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (ren && !rempty) begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  vuart_sync #(.W(PW)) u_wsync (
    .clk (rclk),
    .rst (rrst),
    .d   (wgray),
    .q   (wgray_r)
  );

  assign rempty = (rgray == wgray_r);
  assign rdata  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/vuart_cfg.sv
module vuart_cfg
  import vuart_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                host_en,
  output logic [BASE_W-1:0]   base,
  output logic [IRQ_ID_W-1:0] irq_id,
  output logic [DATA_W-1:0]   rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      host_en <= 1'b0;
      base    <= '0;
      irq_id  <= '0;
    end else if (wr) begin
      case (addr)
        A_CTL:   host_en     <= wdata[0];
        A_BLO:   base[7:0]   <= wdata;
        A_BHI:   base[15:8]  <= wdata;
        A_IRQ:   irq_id      <= wdata[IRQ_ID_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rd_val = DATA_W'(host_en);
      A_BLO:   rd_val = base[7:0];
      A_BHI:   rd_val = base[15:8];
      A_IRQ:   rd_val = DATA_W'(irq_id);
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/vuart_port.sv
module vuart_port
  import vuart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ext_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_full,
  input  logic              tx_empty,
  output logic              rx_pop,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_empty,
  output logic              drop_tgl,
  input  logic              peer_drop_tgl
);
  logic              wr_ok, rd_ok, drop;
  logic [1:0]        ier;
  logic              oe;
  logic              peer_s, peer_q, peer_edge;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ok   = acc_en & wr;
  assign rd_ok   = acc_en & rd;
  assign tx_push = wr_ok && (addr == A_DATA) && !tx_full;
  assign drop    = wr_ok && (addr == A_DATA) && tx_full;
  assign tx_data = wdata;
  assign rx_pop  = rd_ok && (addr == A_DATA) && !rx_empty;

  vuart_sync #(.W(1)) u_drop_sync (
    .clk (clk),
    .rst (rst),
    .d   (peer_drop_tgl),
    .q   (peer_s)
  );
  assign peer_edge = peer_s ^ peer_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_DATA: rd_mux = rx_empty ? '0 : rx_data;
      A_IER:  rd_mux = DATA_W'(ier);
      A_LSR: begin
        rd_mux[LSR_DR]  = !rx_empty;
        rd_mux[LSR_OE]  = oe;
        rd_mux[LSR_TXE] = tx_empty;
      end
      default: rd_mux = ext_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier      <= '0;
      oe       <= 1'b0;
      drop_tgl <= 1'b0;
      peer_q   <= 1'b0;
      rdata    <= '0;
      irq      <= 1'b0;
    end else begin
      peer_q <= peer_s;
      if (drop) drop_tgl <= ~drop_tgl;
      if (wr_ok && addr == A_IER) ier <= wdata[1:0];
      if (peer_edge) oe <= 1'b1;
      else if (rd_ok && addr == A_LSR) oe <= 1'b0;
      if (rd_ok) rdata <= rd_mux;
      irq <= acc_en & ((ier[IER_RX] & !rx_empty) | (ier[IER_TX] & tx_empty));
    end
  end
endmodule

// File: rtl/vuart_bridge.sv
module vuart_bridge
  import vuart_pkg::*;
#(
  parameter int FIFO_AW = DEF_AW
) (
  input  logic                h_clk,
  input  logic                h_rst,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic                h_wr,
  input  logic                h_rd,
  input  logic [DATA_W-1:0]   h_wdata,
  output logic [DATA_W-1:0]   h_rdata,
  output logic                h_irq,
  input  logic                m_clk,
  input  logic                m_rst,
  input  logic [ADDR_W-1:0]   m_addr,
  input  logic                m_wr,
  input  logic                m_rd,
  input  logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W-1:0]   m_rdata,
  output logic                m_irq,
  output logic                cfg_host_en,
  output logic [BASE_W-1:0]   cfg_host_base,
  output logic [IRQ_ID_W-1:0] cfg_host_irq_id
);
  logic              h_en_s;
  logic              h2m_push, h2m_full, h2m_wempty, h2m_pop, h2m_rempty;
  logic              m2h_push, m2h_full, m2h_wempty, m2h_pop, m2h_rempty;
  logic [DATA_W-1:0] h2m_wd, h2m_rd, m2h_wd, m2h_rd;
  logic              h_drop_tgl, m_drop_tgl;
  logic [DATA_W-1:0] m_cfg_rd;

  vuart_cfg u_cfg (
    .clk     (m_clk),
    .rst     (m_rst),
    .wr      (m_wr),
    .addr    (m_addr),
    .wdata   (m_wdata),
    .host_en (cfg_host_en),
    .base    (cfg_host_base),
    .irq_id  (cfg_host_irq_id),
    .rd_val  (m_cfg_rd)
  );

  vuart_sync #(.W(1)) u_en_sync (
    .clk (h_clk),
    .rst (h_rst),
    .d   (cfg_host_en),
    .q   (h_en_s)
  );

  vuart_afifo #(.DW(DATA_W), .AW(FIFO_AW)) u_h2m (
    .wclk (h_clk), .wrst (h_rst), .wen (h2m_push), .wdata (h2m_wd),
    .wfull (h2m_full), .wempty (h2m_wempty),
    .rclk (m_clk), .rrst (m_rst), .ren (h2m_pop), .rdata (h2m_rd),
    .rempty (h2m_rempty)
  );

  vuart_afifo #(.DW(DATA_W), .AW(FIFO_AW)) u_m2h (
    .wclk (m_clk), .wrst (m_rst), .wen (m2h_push), .wdata (m2h_wd),
    .wfull (m2h_full), .wempty (m2h_wempty),
    .rclk (h_clk), .rrst (h_rst), .ren (m2h_pop), .rdata (m2h_rd),
    .rempty (m2h_rempty)
  );

  vuart_port u_hport (
    .clk (h_clk), .rst (h_rst), .acc_en (h_en_s),
    .addr (h_addr), .wr (h_wr), .rd (h_rd), .wdata (h_wdata),
    .ext_rd ('0), .rdata (h_rdata), .irq (h_irq),
    .tx_push (h2m_push), .tx_data (h2m_wd), .tx_full (h2m_full), .tx_empty (h2m_wempty),
    .rx_pop (m2h_pop), .rx_data (m2h_rd), .rx_empty (m2h_rempty),
    .drop_tgl (h_drop_tgl), .peer_drop_tgl (m_drop_tgl)
  );

  vuart_port u_mport (
    .clk (m_clk), .rst (m_rst), .acc_en (1'b1),
    .addr (m_addr), .wr (m_wr), .rd (m_rd), .wdata (m_wdata),
    .ext_rd (m_cfg_rd), .rdata (m_rdata), .irq (m_irq),
    .tx_push (m2h_push), .tx_data (m2h_wd), .tx_full (m2h_full), .tx_empty (m2h_wempty),
    .rx_pop (h2m_pop), .rx_data (h2m_rd), .rx_empty (h2m_rempty),
    .drop_tgl (m_drop_tgl), .peer_drop_tgl (h_drop_tgl)
  );
endmodule

// File: rtl/vuart_bridge_chk.sv
module vuart_bridge_chk (
  input logic       h_clk,
  input logic       h_rst,
  input logic       m_clk,
  input logic       m_rst,
  input logic       h_en_s,
  input logic       h_irq,
  input logic       h2m_push,
  input logic       h2m_full,
  input logic       h2m_rempty,
  input logic       m_rd,
  input logic       m_wr,
  input logic [2:0] m_addr,
  input logic [7:0] m_wdata,
  input logic [7:0] m_rdata,
  input logic       cfg_host_en
);
  AST_HOST_IRQ_QUIET: assert property (@(posedge h_clk) disable iff (h_rst)
    !h_en_s |=> !h_irq); // R8
  AST_HOST_NO_PUSH_DISABLED: assert property (@(posedge h_clk) disable iff (h_rst)
    !h_en_s |-> !h2m_push); // R8
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge h_clk) disable iff (h_rst)
    h2m_push |-> !h2m_full); // R2
  AST_EMPTY_READ_ZERO: assert property (@(posedge m_clk) disable iff (m_rst)
    (m_rd && m_addr == 3'd0 && h2m_rempty) |=> (m_rdata == 8'h00)); // R4
  AST_DR_TRACKS_FIFO: assert property (@(posedge m_clk) disable iff (m_rst)
    (m_rd && m_addr == 3'd2) |=> (m_rdata[0] == !$past(h2m_rempty))); // R4
  AST_CFG_EN_WRITE: assert property (@(posedge m_clk) disable iff (m_rst)
    (m_wr && m_addr == 3'd4) |=> ({7'b0, cfg_host_en} == ($past(m_wdata) & 8'h01))); // R7
endmodule

bind vuart_bridge vuart_bridge_chk u_chk (.*);

// File: tb/vuart_bridge_tb.sv
`timescale 1ns/1ps
module vuart_bridge_tb;
  logic       h_clk = 0, m_clk = 0;
  logic       h_rst = 1, m_rst = 1;
  logic [2:0] h_addr = 0, m_addr = 0;
  logic       h_wr = 0, h_rd = 0, m_wr = 0, m_rd = 0;
  logic [7:0] h_wdata = 0, m_wdata = 0;
  logic [7:0] h_rdata, m_rdata;
  logic       h_irq, m_irq, cfg_host_en;
  logic [15:0] cfg_host_base;
  logic [3:0]  cfg_host_irq_id;

  realtime h_half = 2.5;
  int n_chk = 0, n_bad = 0;

  always #2.5 m_clk = ~m_clk;        // 200 MHz
  always #(h_half) h_clk = ~h_clk;

  vuart_bridge u_dut (.*);

  // {ratio[1:0], count[4:0], pad, start byte}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 5'd5,  1'b0, 8'h10},
    {2'd1, 5'd16, 1'b0, 8'h21},
    {2'd2, 5'd9,  1'b0, 8'hC3},
    {2'd3, 5'd12, 1'b0, 8'h07},
    {2'd2, 5'd16, 1'b0, 8'hF0},
    {2'd0, 5'd1,  1'b0, 8'h99}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic h_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge h_clk); h_addr = a; h_wdata = d; h_wr = 1;
    @(negedge h_clk); h_wr = 0;
  endtask
  task automatic h_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge h_clk); h_addr = a; h_rd = 1;
    @(negedge h_clk); h_rd = 0; d = h_rdata;
  endtask
  task automatic m_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge m_clk); m_addr = a; m_wdata = d; m_wr = 1;
    @(negedge m_clk); m_wr = 0;
  endtask
  task automatic m_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge m_clk); m_addr = a; m_rd = 1;
    @(negedge m_clk); m_rd = 0; d = m_rdata;
  endtask
  task automatic settle();
    #300;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] b;
    repeat (10) @(posedge m_clk);
    @(negedge m_clk); h_rst = 0; m_rst = 0;
    settle();
    // R9 reset state
    check("R9 h_rdata", {8'h0, h_rdata}, 16'h0);
    check("R9 m_rdata", {8'h0, m_rdata}, 16'h0);
    check("R9 irqs", {14'h0, h_irq, m_irq}, 16'h0);
    check("R9 cfg", cfg_host_base | {11'h0, cfg_host_en, cfg_host_irq_id}, 16'h0);
    m_read(3'd2, d); check("R9 m LSR", {8'h0, d}, 16'h0004);

    // R8 host disabled at reset: write must not cross
    h_write(3'd0, 8'hAA); settle();
    m_read(3'd2, d); check("R8 disabled write dropped", {8'h0, d[0]}, 16'h0);

    // R7 configuration
    m_write(3'd4, 8'h01); m_write(3'd5, 8'h34); m_write(3'd6, 8'h12); m_write(3'd7, 8'h1B);
    check("R7 base", cfg_host_base, 16'h1234);
    check("R7 irq id", {12'h0, cfg_host_irq_id}, 16'h000B);
    check("R7 en", {15'h0, cfg_host_en}, 16'h1);
    m_read(3'd7, d); check("R7 readback", {8'h0, d}, 16'h000B);
    settle();
    h_write(3'd4, 8'h00); h_write(3'd5, 8'hFF); settle();
    check("R7 host cannot write cfg", {cfg_host_en, 3'b0, cfg_host_base[11:0]}, 16'h8234);

    // R6 / R5 host irq on tx-empty
    h_write(3'd1, 8'h02); settle();
    check("R6 h_irq txe", {15'h0, h_irq}, 16'h1);
    h_read(3'd2, d); check("R5 h LSR empty", {8'h0, d}, 16'h0004);

    // R8 disable: irq low, reads and writes ignored
    m_write(3'd4, 8'h00); settle();
    check("R8 h_irq held low", {15'h0, h_irq}, 16'h0);
    h_read(3'd1, d); check("R8 rdata holds", {8'h0, d}, 16'h0004);
    h_write(3'd1, 8'h00); h_write(3'd0, 8'h5A); settle();
    m_read(3'd2, d); check("R8 no push while disabled", {8'h0, d}, 16'h0004);
    m_write(3'd4, 8'h01); settle();
    check("R8 IER kept", {15'h0, h_irq}, 16'h1);
    h_write(3'd1, 8'h00); settle();

    // R1 table of ratios
    foreach (VEC[v]) begin
      case (VEC[v][15:14])
        2'd0: h_half = 7.5;
        2'd1: h_half = 2.5;
        2'd2: h_half = 0.8333;
        default: h_half = 3.75;
      endcase
      settle();
      for (int i = 0; i < VEC[v][13:9]; i++) h_write(3'd0, VEC[v][7:0] + 8'(i * 7));
      settle();
      for (int i = 0; i < VEC[v][13:9]; i++) begin
        m_read(3'd0, d); b = VEC[v][7:0] + 8'(i * 7);
        check("R1 h->m order", {8'h0, d}, {8'h0, b});
      end
      m_read(3'd2, d); check("R4 h->m count", {8'h0, d}, 16'h0004);
      for (int i = 0; i < VEC[v][13:9]; i++) m_write(3'd0, ~(VEC[v][7:0] + 8'(i * 5)));
      settle();
      for (int i = 0; i < VEC[v][13:9]; i++) begin
        h_read(3'd0, d); b = ~(VEC[v][7:0] + 8'(i * 5));
        check("R1 m->h order", {8'h0, d}, {8'h0, b});
      end
      h_read(3'd2, d); check("R4 m->h count", {8'h0, d}, 16'h0004);
    end
    h_half = 2.5; settle();

    // R2 / R3 overrun
    for (int i = 0; i < 17; i++) h_write(3'd0, 8'h40 + 8'(i));
    settle();
    h_read(3'd2, d); check("R5 h TXE clear when pending", {8'h0, d}, 16'h0000);
    m_read(3'd2, d); check("R3 overrun set", {8'h0, d}, 16'h0007);
    m_read(3'd2, d); check("R3 overrun cleared", {8'h0, d}, 16'h0005);
    m_write(3'd1, 8'h01); settle();
    check("R6 m_irq rx", {15'h0, m_irq}, 16'h1);
    for (int i = 0; i < 16; i++) begin
      m_read(3'd0, d); check("R2 kept bytes", {8'h0, d}, {8'h0, 8'h40 + 8'(i)});
    end
    m_read(3'd2, d); check("R2 17th dropped", {8'h0, d}, 16'h0004);
    settle();
    check("R6 m_irq rx cleared", {15'h0, m_irq}, 16'h0);
    h_read(3'd2, d); check("R5 h TXE after drain", {8'h0, d}, 16'h0004);
    m_write(3'd1, 8'h02); settle();
    check("R6 m_irq txe", {15'h0, m_irq}, 16'h1);
    m_write(3'd1, 8'h00);

    // R4 empty read, R10 hold
    m_read(3'd0, d); check("R4 empty read zero", {8'h0, d}, 16'h0);
    m_read(3'd2, d);
    repeat (10) @(negedge m_clk);
    check("R10 rdata holds", {8'h0, m_rdata}, 16'h0004);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule